// File: doc/BRIEF.md
# 128-bit Lane Permutation Unit

This block rearranges the elements of two 128-bit operands into a new 128-bit value in a single pass. It serves a multimedia datapath: packing, interleaving, replicating and rotating lanes without any arithmetic. Each request carries two source register indices, a destination index and an operation code. A source index of zero stands for a hard-wired zero register, so that operand is read as all zeros. A destination index of zero stands for the same discard register, so the result is produced but not written.

The result is registered. It appears one clock after the request, together with a valid flag, a write enable and the destination index. Words are numbered 0 (bits 31:0) to 3 (bits 127:96). Halfwords are numbered 0 to 7 and bytes 0 to 15, counting from bit 0 in the same way. The operand named S is `opnd_s` and the operand named T is `opnd_t`.

Top module: `perm128_unit`

## Requirements
- R1: Op code 0 (pack words) gives result word0 = T word0, word1 = T word2, word2 = S word0 and word3 = S word2.
- R2: Op codes 1, 2 and 3 interleave the lower 64 bits of both sources, using 8-, 16- and 32-bit elements in that order. Result element 2i is T element i and result element 2i+1 is S element i, for i = 0 up to 64/width - 1.
- R3: Op code 4 works like op code 3 but takes the upper 64 bits of each source. The result is S word3, T word3, S word2, T word2, from word3 down to word0.
- R4: Op code 5 copies T halfword 0 into halfwords 0 to 3 and T halfword 4 into halfwords 4 to 7.
- R5: Op code 6 places S bits 63:0 in result bits 127:64 and T bits 63:0 in result bits 63:0.
- R6: Op code 7 places S bits 127:64 in result bits 63:0 and T bits 127:64 in result bits 127:64.
- R7: Op code 8 gives result word0 = T word1, word1 = T word2, word2 = T word0 and word3 = T word3.
- R8: A request with destination index 0 gives `out_valid` = 1 and `out_wr_en` = 0. `out_dst` is 0.
- R9: A source index of 0 makes that operand read as all zeros, whatever value is on its data input.
- R10: `out_valid` is `in_valid` delayed by one clock. When no request is present, `out_data`, `out_dst` and `out_wr_en` keep their previous values, except that `out_wr_en` drops to 0.
- R11: Op codes 9 to 15 are undefined. They give `out_data` = 0 and `out_wr_en` = 0, while `out_valid` is still 1.
- R12: During reset, `out_valid`, `out_wr_en`, `out_dst` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| op_sel | input | 4 | Operation code (see R1 to R7 and R11) |
| src_s_idx | input | 5 | Register index of operand S; 0 reads as zero |
| src_t_idx | input | 5 | Register index of operand T; 0 reads as zero |
| dst_idx | input | 5 | Destination index; 0 discards the result |
| opnd_s | input | 128 | Operand S data |
| opnd_t | input | 128 | Operand T data |
| out_valid | output | 1 | Result present, one cycle after the request |
| out_wr_en | output | 1 | Result is to be written to `out_dst` |
| out_dst | output | 5 | Destination index of the result |
| out_data | output | 128 | Permuted 128-bit result |

## Verification
Every result of this block is due exactly one rising edge after its request is applied, and there is no other latency path. The bench applies each request just after a falling edge. It computes the expected outputs at that moment and compares all four outputs at the next falling edge, half a period after the registering edge. Idle cycles are compared in the same way, so the expectations that outputs hold their values (R10) and that the write enable drops are checked on every clock. Back-to-back requests are also covered, which shows that the result of one request never leaks into the cycle of the next.

// File: rtl/perm128_pkg.sv
// Package: shared operation codes for the lane permutation unit.
// Assumes a 4-bit operation field; codes above OP_ROT3W are undefined.
package perm128_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PACKW  = 4'd0,
        OP_ILV_LB = 4'd1,
        OP_ILV_LH = 4'd2,
        OP_ILV_LW = 4'd3,
        OP_ILV_UW = 4'd4,
        OP_REPH   = 4'd5,
        OP_CPY_LD = 4'd6,
        OP_CPY_UD = 4'd7,
        OP_ROT3W  = 4'd8
    } perm_op_e;

    // True for the codes the unit implements.
    function automatic logic op_is_defined(input logic [OP_W-1:0] code);
        return code <= OP_ROT3W;
    endfunction

endpackage

// File: rtl/perm_src_gate.sv
// Module: perm_src_gate
// Forces an operand to zero when its register index selects the zero register.
// Assumes index 0 is the hard-wired zero register.
module perm_src_gate #(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Zero the operand for index 0, pass it through otherwise.
    always_comb begin
        dout = (idx == '0) ? '0 : din;
    end

endmodule

// File: rtl/perm_interleave.sv
// Module: perm_interleave
// Interleaves two HALF_W-bit slices element by element, with the T element in
// the even slot and the S element in the odd slot.
// Assumes ELEM_W divides HALF_W.
module perm_interleave #(
    parameter int HALF_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic [HALF_W-1:0]   half_s,
    input  logic [HALF_W-1:0]   half_t,
    output logic [2*HALF_W-1:0] mixed
);

    localparam int N_ELEM = HALF_W / ELEM_W;

    for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
        // Place T element i at slot 2i and S element i at slot 2i+1.
        always_comb begin
            mixed[(2*i)*ELEM_W   +: ELEM_W] = half_t[i*ELEM_W +: ELEM_W];
            mixed[(2*i+1)*ELEM_W +: ELEM_W] = half_s[i*ELEM_W +: ELEM_W];
        end
    end

endmodule

// File: rtl/perm_shuffle_core.sv
// Module: perm_shuffle_core
// Combinational selector that builds every permutation and picks one by
// operation code. Undefined codes yield zero.
// Assumes DATA_W is a multiple of 64.
module perm_shuffle_core
    import perm128_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_s,
    input  logic [DATA_W-1:0] src_t,
    output logic [DATA_W-1:0] result
);

    localparam int HALF_W = DATA_W / 2;
    localparam int WORD_W = DATA_W / 4;
    localparam int HW_W   = DATA_W / 8;
    localparam int N_ILV  = 3;

    logic [N_ILV-1:0][DATA_W-1:0] ilv_lo;
    logic [DATA_W-1:0]            ilv_hi_w;

    // Lower-half interleaves at element widths HW_W/2, HW_W and WORD_W.
    for (genvar g = 0; g < N_ILV; g++) begin : g_ilv_lo
        perm_interleave #(
            .HALF_W (HALF_W),
            .ELEM_W ((HW_W / 2) << g)
        ) u_ilv (
            .half_s (src_s[HALF_W-1:0]),
            .half_t (src_t[HALF_W-1:0]),
            .mixed  (ilv_lo[g])
        );
    end

    perm_interleave #(
        .HALF_W (HALF_W),
        .ELEM_W (WORD_W)
    ) u_ilv_hi (
        .half_s (src_s[DATA_W-1:HALF_W]),
        .half_t (src_t[DATA_W-1:HALF_W]),
        .mixed  (ilv_hi_w)
    );

    // Select the permutation requested by the operation code.
    always_comb begin
        result = '0;
        case (op)
            OP_PACKW:  result = {src_s[2*WORD_W +: WORD_W], src_s[0 +: WORD_W],
                                 src_t[2*WORD_W +: WORD_W], src_t[0 +: WORD_W]};
            OP_ILV_LB: result = ilv_lo[0];
            OP_ILV_LH: result = ilv_lo[1];
            OP_ILV_LW: result = ilv_lo[2];
            OP_ILV_UW: result = ilv_hi_w;
            OP_REPH:   result = {{4{src_t[4*HW_W +: HW_W]}}, {4{src_t[0 +: HW_W]}}};
            OP_CPY_LD: result = {src_s[HALF_W-1:0], src_t[HALF_W-1:0]};
            OP_CPY_UD: result = {src_t[DATA_W-1:HALF_W], src_s[DATA_W-1:HALF_W]};
            OP_ROT3W:  result = {src_t[3*WORD_W +: WORD_W], src_t[0 +: WORD_W],
                                 src_t[2*WORD_W +: WORD_W], src_t[1*WORD_W +: WORD_W]};
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/perm_out_reg.sv
// Module: perm_out_reg
// Result register: captures data and destination on a valid request and
// raises the write enable only for a real destination.
// Assumes a synchronous active-low reset.
module perm_out_reg #(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_wr,
    input  logic [IDX_W-1:0]  cap_dst,
    input  logic [DATA_W-1:0] cap_data,
    output logic              q_valid,
    output logic              q_wr_en,
    output logic [IDX_W-1:0]  q_dst,
    output logic [DATA_W-1:0] q_data
);

    // Valid and write-enable flags follow each request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_wr_en <= 1'b0;
        end else begin
            q_valid <= cap_en;
            q_wr_en <= cap_en & cap_wr;
        end
    end

    // Payload is captured on a request and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_dst  <= '0;
            q_data <= '0;
        end else if (cap_en) begin
            q_dst  <= cap_dst;
            q_data <= cap_data;
        end
    end

endmodule

// File: rtl/perm128_unit.sv
// Module: perm128_unit (top)
// 128-bit lane permutation unit with a registered result.
// Assumes the index 0 register reads as zero and discards writes.
module perm128_unit
    import perm128_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [IDX_W-1:0]  src_s_idx,
    input  logic [IDX_W-1:0]  src_t_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [DATA_W-1:0] opnd_s,
    input  logic [DATA_W-1:0] opnd_t,
    output logic              out_valid,
    output logic              out_wr_en,
    output logic [IDX_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] gated_s;
    logic [DATA_W-1:0] gated_t;
    logic [DATA_W-1:0] perm_res;
    logic              do_write;

    perm_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_s (
        .idx (src_s_idx), .din (opnd_s), .dout (gated_s)
    );

    perm_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_t (
        .idx (src_t_idx), .din (opnd_t), .dout (gated_t)
    );

    perm_shuffle_core #(.DATA_W(DATA_W)) u_core (
        .op     (op_sel),
        .src_s  (gated_s),
        .src_t  (gated_t),
        .result (perm_res)
    );

    // Write only to a real destination with a defined operation.
    always_comb begin
        do_write = (dst_idx != '0) && op_is_defined(op_sel);
    end

    perm_out_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (in_valid),
        .cap_wr   (do_write),
        .cap_dst  (dst_idx),
        .cap_data (perm_res),
        .q_valid  (out_valid),
        .q_wr_en  (out_wr_en),
        .q_dst    (out_dst),
        .q_data   (out_data)
    );

endmodule

// File: rtl/perm128_unit_chk.sv
// Module: perm128_unit_chk
// Protocol and placement checks for perm128_unit, attached by bind.
module perm128_unit_chk #(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_sel,
    input logic [IDX_W-1:0]  src_s_idx,
    input logic [IDX_W-1:0]  src_t_idx,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [DATA_W-1:0] opnd_s,
    input logic [DATA_W-1:0] opnd_t,
    input logic              out_valid,
    input logic              out_wr_en,
    input logic [IDX_W-1:0]  out_dst,
    input logic [DATA_W-1:0] out_data
);

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_en));

    assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_dst)));

    assert_no_write_dst0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_idx == '0) |=> !out_wr_en);

    assert_undef_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel > 4'd8) |=> (!out_wr_en && out_data == '0));

    assert_copy_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd6 && src_s_idx != '0 && src_t_idx != '0) |=>
        (out_data == {$past(opnd_s[DATA_W/2-1:0]), $past(opnd_t[DATA_W/2-1:0])}));

    assert_zero_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd6 && src_s_idx == '0) |=>
        (out_data[DATA_W-1:DATA_W/2] == '0));

    assert_wr_implies_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (out_valid && out_dst != '0));

endmodule

bind perm128_unit perm128_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src_s_idx (src_s_idx),
    .src_t_idx (src_t_idx),
    .dst_idx   (dst_idx),
    .opnd_s    (opnd_s),
    .opnd_t    (opnd_t),
    .out_valid (out_valid),
    .out_wr_en (out_wr_en),
    .out_dst   (out_dst),
    .out_data  (out_data)
);

// File: tb/perm128_unit_test.sv
`timescale 1ns/1ps
module perm128_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op_sel = '0;
    logic [4:0]   src_s_idx = '0;
    logic [4:0]   src_t_idx = '0;
    logic [4:0]   dst_idx = '0;
    logic [127:0] opnd_s = '0;
    logic [127:0] opnd_t = '0;
    logic         out_valid;
    logic         out_wr_en;
    logic [4:0]   out_dst;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, updated behaviourally when a request is applied.
    logic         e_valid = 1'b0;
    logic         e_wr = 1'b0;
    logic [4:0]   e_dst = '0;
    logic [127:0] e_data = '0;

    always #5 clk = ~clk;

    perm128_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_s_idx(src_s_idx), .src_t_idx(src_t_idx), .dst_idx(dst_idx),
        .opnd_s(opnd_s), .opnd_t(opnd_t), .out_valid(out_valid),
        .out_wr_en(out_wr_en), .out_dst(out_dst), .out_data(out_data)
    );

    function automatic logic [31:0] wd(input logic [127:0] v, input int n);
        return v[n*32 +: 32];
    endfunction

    // Behavioural model of the permutations, bit by bit.
    function automatic logic [127:0] model(input int op, input logic [127:0] s,
                                           input logic [127:0] t);
        logic [127:0] r = '0;
        int w;
        case (op)
            0: r = {wd(s,2), wd(s,0), wd(t,2), wd(t,0)};
            1, 2, 3, 4: begin
                w = (op == 4) ? 32 : (4 << op);
                for (int b = 0; b < 128; b++) begin
                    int el = b / w;
                    int src_bit = (el / 2) * w + (b % w) + ((op == 4) ? 64 : 0);
                    r[b] = (el % 2 == 1) ? s[src_bit] : t[src_bit];
                end
            end
            5: for (int h = 0; h < 8; h++)
                   r[h*16 +: 16] = (h < 4) ? t[15:0] : t[79:64];
            6: r = {s[63:0], t[63:0]};
            7: r = {t[127:64], s[127:64]};
            8: r = {wd(t,3), wd(t,0), wd(t,2), wd(t,1)};
            default: r = '0;
        endcase
        return r;
    endfunction

    // Compare all outputs against the reference at the current instant.
    task automatic compare(input string req);
        checks++;
        if (out_valid !== e_valid || out_wr_en !== e_wr || out_dst !== e_dst ||
            out_data !== e_data) begin
            errors++;
            $display("FAIL %s: valid/wr/dst/data = %b/%b/%0d/%h expected %b/%b/%0d/%h",
                     req, out_valid, out_wr_en, out_dst, out_data,
                     e_valid, e_wr, e_dst, e_data);
        end
    endtask

    // Apply one cycle of stimulus after a falling edge, check at the next one.
    task automatic step(input string req, input bit v, input int op, input int si,
                        input int ti, input int di, input logic [127:0] s,
                        input logic [127:0] t);
        logic [127:0] gs, gt;
        in_valid = v; op_sel = op[3:0]; src_s_idx = si[4:0]; src_t_idx = ti[4:0];
        dst_idx = di[4:0]; opnd_s = s; opnd_t = t;
        gs = (si == 0) ? '0 : s;
        gt = (ti == 0) ? '0 : t;
        e_valid = v;
        e_wr = v && di != 0 && op <= 8;
        if (v) begin
            e_dst = di[4:0];
            e_data = model(op, gs, gt);
        end
        @(negedge clk);
        compare(req);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    localparam logic [127:0] PS = 128'h33333333_22222222_11111111_00000000;
    localparam logic [127:0] PT = 128'hBBBBBBBB_AAAAAAAA_99999999_88888888;
    localparam logic [127:0] BS = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
    localparam logic [127:0] BT = 128'h0F0E0D0C_0B0A0908_07060504_03020100;

    initial begin
        repeat (3) @(negedge clk);
        compare("R12");            // outputs zero during reset
        rst_n = 1'b1;
        step("R10 idle", 0, 0, 1, 2, 3, PS, PT);
        step("R1 pack", 1, 0, 1, 2, 3, PS, PT);
        step("R2 ilv byte", 1, 1, 4, 5, 6, BS, BT);
        step("R2 ilv half", 1, 2, 4, 5, 7, BS, BT);
        step("R2 ilv word", 1, 3, 4, 5, 8, BS, BT);
        step("R3 ilv upper word", 1, 4, 4, 5, 9, PS, PT);
        step("R4 replicate", 1, 5, 4, 5, 10, BS, BT);
        step("R5 copy lower", 1, 6, 1, 2, 11, PS, PT);
        step("R6 copy upper", 1, 7, 1, 2, 12, PS, PT);
        step("R7 rotate", 1, 8, 1, 2, 13, PS, PT);
        step("R10 hold", 0, 7, 1, 2, 14, BS, BT);
        step("R10 hold2", 0, 0, 0, 0, 0, '0, '0);
        step("R8 dst zero", 1, 0, 1, 2, 0, PS, PT);
        step("R9 s zero", 1, 6, 0, 2, 3, PS, PT);
        step("R9 t zero", 1, 8, 1, 0, 3, PS, PT);
        step("R11 undef op", 1, 9, 1, 2, 3, PS, PT);
        step("R11 undef op 15", 1, 15, 1, 2, 3, PS, PT);
        for (int k = 0; k < 300; k++) begin
            int op = $urandom_range(0, 15);
            step($sformatf("R%0d random", (op > 8) ? 11 : ((op == 0) ? 1 :
                 (op < 4) ? 2 : op - 1)), $urandom_range(0, 3) != 0, op,
                 $urandom_range(0, 31), $urandom_range(0, 31),
                 $urandom_range(0, 31), rnd128(), rnd128());
        end
        rst_n = 1'b0;
        in_valid = 1'b0;
        e_valid = 0; e_wr = 0; e_dst = '0; e_data = '0;
        @(negedge clk);
        compare("R12 re-reset");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule